// File: doc/BRIEF.md
# Predicated Two-Level Element Step Iterator

This block keeps the position of one operand side of a vector operation as a pair of counters: an element index running from 0 to VL-1 and a sub-element index running from 0 to SUBVL inclusive, where SUBVL is the stored field value. Each pulse of the advance input moves the pair one step through the nested loop and raises a one-cycle loop-end flag when the whole space has been covered.

By default the sub-element index is the inner loop. A run-time order flag swaps the nesting so that the element index becomes the inner loop. A skip flag with a predicate mask lets the element index pass over masked-out positions in a single cycle, so one advance may move it by several places. The same module serves the source side or the destination side; the surrounding logic chooses which order flag, skip flag and mask to feed in. A load port restores a saved position, for example after a context switch.

Top module: `stepIterator`

## Requirements
- R1: In normal order (swapOrder=0), an advance with curSub not equal to subvl increments curSub by one and leaves curStep unchanged.
- R2: In normal order, an advance with curSub equal to subvl sets curSub to 0 and moves curStep to its next position. If there is no next position, it takes the end rule of R4.
- R3: In swapped order (swapOrder=1), an advance moves curStep to its next position and leaves curSub unchanged. When there is no next position and curSub is not equal to subvl, curStep becomes 0 and curSub increments, with no mask test on position 0.
- R4: The end rule applies to an advance that finds no next element position while curSub equals subvl. It leaves curStep=0 and curSub=0, and it raises loopEnd for exactly the cycle following that clock edge.
- R5: With skipEn=0, the next position is curStep+1 when that is below vl. Otherwise there is none.
- R6: With skipEn=1, the next position is the lowest index k with curStep < k < vl and predMask[k]=1. Bit k of predMask belongs to element k. Otherwise there is none.
- R7: With advance and loadEn both low, curStep and curSub hold and loopEnd is low in the following cycle.
- R8: loadEn takes priority over advance. On the next edge it copies loadStep and loadSub into curStep and curSub, and loopEnd stays low.
- R9: While rstN is low, curStep, curSub and loopEnd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| advance | input | 1 | Step the position once on this edge |
| loadEn | input | 1 | Load the position from loadStep/loadSub |
| loadStep | input | STEP_W | Element index to load |
| loadSub | input | 2 | Sub-element index to load |
| vl | input | STEP_W+1 | Element count, 1 to MAX_VL |
| subvl | input | 2 | Last sub-element index (inclusive) |
| swapOrder | input | 1 | 1: element index is the inner loop |
| skipEn | input | 1 | 1: pass over elements whose mask bit is 0 |
| predMask | input | MAX_VL | Predicate mask, bit k for element k |
| curStep | output | STEP_W | Current element index |
| curSub | output | 2 | Current sub-element index |
| loopEnd | output | 1 | One-cycle pulse after the final advance |

## Verification
The bench builds the block with MAX_VL=8, so the element counter is 3 bits wide and the mask is 8 bits wide. At that size it can cover every element count, every subvl value, both loop orders and every valid start position, with skipping both off and on under several masks, including all-zero, all-one and sparse patterns. Full walks from position zero then measure the number of advances before loopEnd in both orders. The end rule, the unmasked restart at position 0 in swapped order, and the search that finds no set bit all occur many times within this sweep.

// File: rtl/stepIterPkg.sv
package stepIterPkg;
  typedef struct packed {
    logic load;      // copy load port into state
    logic incSub;    // sub-element index + 1
    logic clrSub;    // sub-element index to 0
    logic moveStep;  // element index to searched position
    logic wrapStep;  // element index to 0
    logic endPulse;  // raise loopEnd next cycle
  } stepCtrlT;
endpackage

// File: rtl/stepSearch.sv
module stepSearch #(
  parameter int MAX_VL = 64,
  localparam int STEP_W = $clog2(MAX_VL),
  localparam int VL_W = STEP_W + 1
) (
  input  logic [STEP_W-1:0] curStep,
  input  logic [VL_W-1:0]   vl,
  input  logic              skipEn,
  input  logic [MAX_VL-1:0] predMask,
  output logic              found,
  output logic [STEP_W-1:0] nextIdx
);
  logic [MAX_VL-1:0] eligible;

  for (genvar k = 0; k < MAX_VL; k++) begin : gElig
    assign eligible[k] = (VL_W'(k) > {1'b0, curStep}) && (VL_W'(k) < vl)
                         && (!skipEn || predMask[k]);
  end

  // lowest eligible index wins
  always_comb begin
    found = 1'b0;
    nextIdx = '0;
    for (int k = MAX_VL - 1; k >= 0; k--) begin
      if (eligible[k]) begin
        found = 1'b1;
        nextIdx = STEP_W'(k);
      end
    end
  end
endmodule

// File: rtl/stepCtrl.sv
module stepCtrl
  import stepIterPkg::*;
(
  input  logic       advance,
  input  logic       loadEn,
  input  logic       swapOrder,
  input  logic [1:0] curSub,
  input  logic [1:0] subvl,
  input  logic       found,
  output stepCtrlT   ctrl
);
  logic subEnd;
  assign subEnd = (curSub == subvl);

  always_comb begin
    ctrl = '0;
    if (loadEn) begin
      ctrl.load = 1'b1;
    end else if (advance) begin
      if (!swapOrder) begin
        if (!subEnd) begin
          ctrl.incSub = 1'b1;
        end else begin
          ctrl.clrSub = 1'b1;
          if (found) begin
            ctrl.moveStep = 1'b1;
          end else begin
            ctrl.wrapStep = 1'b1;
            ctrl.endPulse = 1'b1;
          end
        end
      end else begin
        if (found) begin
          ctrl.moveStep = 1'b1;
        end else begin
          ctrl.wrapStep = 1'b1;
          if (subEnd) begin
            ctrl.clrSub = 1'b1;
            ctrl.endPulse = 1'b1;
          end else begin
            ctrl.incSub = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stepDatapath.sv
module stepDatapath
  import stepIterPkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int STEP_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtrlT          ctrl,
  input  logic [STEP_W-1:0] loadStep,
  input  logic [1:0]        loadSub,
  input  logic [STEP_W-1:0] nextIdx,
  output logic [STEP_W-1:0] curStep,
  output logic [1:0]        curSub,
  output logic              loopEnd
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curStep <= '0;
      curSub  <= '0;
      loopEnd <= 1'b0;
    end else begin
      loopEnd <= ctrl.endPulse;
      if (ctrl.load)          curStep <= loadStep;
      else if (ctrl.moveStep) curStep <= nextIdx;
      else if (ctrl.wrapStep) curStep <= '0;
      if (ctrl.load)        curSub <= loadSub;
      else if (ctrl.clrSub) curSub <= '0;
      else if (ctrl.incSub) curSub <= curSub + 2'd1;
    end
  end
endmodule

// File: rtl/stepIterator.sv
module stepIterator
  import stepIterPkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int STEP_W = $clog2(MAX_VL),
  localparam int VL_W = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              loadEn,
  input  logic [STEP_W-1:0] loadStep,
  input  logic [1:0]        loadSub,
  input  logic [VL_W-1:0]   vl,
  input  logic [1:0]        subvl,
  input  logic              swapOrder,
  input  logic              skipEn,
  input  logic [MAX_VL-1:0] predMask,
  output logic [STEP_W-1:0] curStep,
  output logic [1:0]        curSub,
  output logic              loopEnd
);
  stepCtrlT ctrl;
  logic found;
  logic [STEP_W-1:0] nextIdx;

  stepSearch #(.MAX_VL(MAX_VL)) uSearch (
    .curStep(curStep), .vl(vl), .skipEn(skipEn), .predMask(predMask),
    .found(found), .nextIdx(nextIdx)
  );

  stepCtrl uCtrl (
    .advance(advance), .loadEn(loadEn), .swapOrder(swapOrder),
    .curSub(curSub), .subvl(subvl), .found(found), .ctrl(ctrl)
  );

  stepDatapath #(.MAX_VL(MAX_VL)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loadStep(loadStep),
    .loadSub(loadSub), .nextIdx(nextIdx), .curStep(curStep),
    .curSub(curSub), .loopEnd(loopEnd)
  );
endmodule

// File: rtl/stepIterChecker.sv
module stepIterChecker #(
  parameter int MAX_VL = 64,
  localparam int STEP_W = $clog2(MAX_VL),
  localparam int VL_W = STEP_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              advance,
  input logic              loadEn,
  input logic [STEP_W-1:0] loadStep,
  input logic [1:0]        loadSub,
  input logic [VL_W-1:0]   vl,
  input logic [1:0]        subvl,
  input logic              swapOrder,
  input logic [STEP_W-1:0] curStep,
  input logic [1:0]        curSub,
  input logic              loopEnd
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !advance) |=> ($stable(curStep) && $stable(curSub) && !loopEnd));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (curStep == $past(loadStep) && curSub == $past(loadSub) && !loopEnd));

  assert_end_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    loopEnd |-> (curStep == '0 && curSub == 2'd0));

  assert_inner_sub_R1: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !loadEn && !swapOrder && curSub != subvl)
      |=> (curSub == $past(curSub) + 2'd1 && curStep == $past(curStep) && !loopEnd));

  assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !loadEn) |=> ({1'b0, curStep} < $past(vl)));
endmodule

bind stepIterator stepIterChecker #(.MAX_VL(MAX_VL)) uChk (
  .clk(clk), .rstN(rstN), .advance(advance), .loadEn(loadEn),
  .loadStep(loadStep), .loadSub(loadSub), .vl(vl), .subvl(subvl),
  .swapOrder(swapOrder), .curStep(curStep), .curSub(curSub), .loopEnd(loopEnd)
);

// File: tb/tb_stepIterator.sv
module tb_stepIterator;
  localparam int MAXV = 8;
  localparam int SW = $clog2(MAXV);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advance = 1'b0, loadEn = 1'b0;
  logic [SW-1:0] loadStep = '0;
  logic [1:0] loadSub = '0;
  logic [SW:0] vl = (SW+1)'(MAXV);
  logic [1:0] subvl = '0;
  logic swapOrder = 1'b0, skipEn = 1'b0;
  logic [MAXV-1:0] predMask = '0;
  logic [SW-1:0] curStep;
  logic [1:0] curSub;
  logic loopEnd;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  stepIterator #(.MAX_VL(MAXV)) dut (
    .clk(clk), .rstN(rstN), .advance(advance), .loadEn(loadEn),
    .loadStep(loadStep), .loadSub(loadSub), .vl(vl), .subvl(subvl),
    .swapOrder(swapOrder), .skipEn(skipEn), .predMask(predMask),
    .curStep(curStep), .curSub(curSub), .loopEnd(loopEnd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected next position from the requirements
  task automatic model(input int st, input int sb, input int n, input int sv,
                       input bit sw, input bit sk, input logic [MAXV-1:0] m,
                       output int ns, output int nsb, output bit ne);
    bit has = 1'b0;
    int nx = 0;
    for (int k = st + 1; k < n; k++)
      if (!has && (!sk || m[k])) begin has = 1'b1; nx = k; end
    ne = 1'b0;
    if (!sw) begin
      if (sb != sv) begin ns = st; nsb = sb + 1; end
      else if (has) begin ns = nx; nsb = 0; end
      else begin ns = 0; nsb = 0; ne = 1'b1; end
    end else begin
      if (has) begin ns = nx; nsb = sb; end
      else if (sb != sv) begin ns = 0; nsb = sb + 1; end
      else begin ns = 0; nsb = 0; ne = 1'b1; end
    end
  endtask

  task automatic oneStep(input int st, input int sb, input string tag);
    int es, esb; bit ee;
    @(negedge clk);
    loadEn = 1'b1; loadStep = SW'(st); loadSub = 2'(sb); advance = 1'b1;
    @(negedge clk);
    loadEn = 1'b0; advance = 1'b0;
    check(curStep == SW'(st) && curSub == 2'(sb) && !loopEnd, "R8 load",
          int'(curStep) * 4 + int'(curSub), st * 4 + sb);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    model(st, sb, int'(vl), int'(subvl), swapOrder, skipEn, predMask, es, esb, ee);
    check(int'(curStep) == es, tag, int'(curStep), es);
    check(int'(curSub) == esb, tag, int'(curSub), esb);
    check(loopEnd == ee, "R4 loopEnd", int'(loopEnd), int'(ee));
    @(negedge clk);
    check(!loopEnd && int'(curStep) == es && int'(curSub) == esb, "R7 hold",
          int'(loopEnd), 0);
  endtask

  logic [MAXV-1:0] masks [5] = '{8'h00, 8'hFF, 8'hA5, 8'h12, 8'h81};

  initial begin
    #1_500_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    advance = 1'b1;
    @(negedge clk);
    check(curStep == '0 && curSub == 2'd0 && !loopEnd, "R9 reset", int'(curStep), 0);
    advance = 1'b0;
    rstN = 1'b1;

    // sweep: R1 R2 R3 R5 R6 from every valid start position
    for (int n = 1; n <= MAXV; n++) begin
      for (int sv = 0; sv < 4; sv++) begin
        for (int sw = 0; sw < 2; sw++) begin
          for (int mi = -1; mi < 5; mi++) begin
            vl = (SW+1)'(n); subvl = 2'(sv); swapOrder = sw[0];
            skipEn = (mi >= 0);
            predMask = (mi >= 0) ? masks[mi] : 8'h00;
            for (int st = 0; st < n; st++)
              for (int sb = 0; sb <= sv; sb++)
                oneStep(st, sb, sw == 1 ? "R3 swapped" :
                        (mi >= 0 ? "R6 skip" : (sb == sv ? "R2 outer" : "R1 inner")));
          end
        end
      end
    end

    // full walks with skipping off: R5 count of advances to loopEnd
    for (int sw = 0; sw < 2; sw++) begin
      int cnt = 0; bit seen = 1'b0;
      @(negedge clk);
      vl = (SW+1)'(5); subvl = 2'd2; swapOrder = sw[0]; skipEn = 1'b0;
      loadEn = 1'b1; loadStep = '0; loadSub = '0;
      @(negedge clk);
      loadEn = 1'b0; advance = 1'b1;
      while (!seen && cnt < 40) begin
        @(negedge clk);
        cnt++;
        seen = loopEnd;
      end
      advance = 1'b0;
      check(cnt == 15, "R5 walk length", cnt, 15);
      check(curStep == '0 && curSub == 2'd0, "R4 wrap state", int'(curStep), 0);
    end

    // skip walk, swapped order, mask 0x12 with vl=8 subvl=1: elements 0,1,4 per pass
    begin
      int cnt = 0; bit seen = 1'b0;
      @(negedge clk);
      vl = (SW+1)'(8); subvl = 2'd1; swapOrder = 1'b1; skipEn = 1'b1; predMask = 8'h12;
      loadEn = 1'b1; loadStep = '0; loadSub = '0;
      @(negedge clk);
      loadEn = 1'b0; advance = 1'b1;
      while (!seen && cnt < 40) begin
        @(negedge clk);
        cnt++;
        seen = loopEnd;
      end
      advance = 1'b0;
      check(cnt == 6, "R6 skip walk length", cnt, 6);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule